// File: doc/BRIEF.md
# Sparse Cartesian-Product Convolution Processing Element

This block is one processing element of a convolution engine that works only on non-zero operands. It holds a small set of non-zero input activations in place, each with its input channel and its position inside the element's planar tile. Vectors of non-zero filter weights then stream in one per step. Each weight carries its output channel, its input channel and its kernel offsets. In every accepted step the element multiplies each valid weight by each valid activation. For each product it works out the output position as activation position minus kernel offset, and it adds the product into a local accumulation buffer.

The buffer covers the tile extended by a margin of kernel-size-minus-one on the low side of each axis. Partial sums at negative coordinates belong to a neighbouring element and are marked as halo values when read out. Products that land on the same buffer entry within one step are summed before the write, so the weight input never has to stall because of a collision. A clear command zeroes the buffer. A drain command streams every entry out over a valid/ready port, together with its coordinates and halo flag.

Top module: `sparse_cp_pe`

## Requirements
- R1: After reset, rd_valid is 0, wt_ready is 1 and every buffer entry reads back as zero.
- R2: In a cycle with wt_valid and wt_ready both high, each product of a valid weight lane f and a valid activation lane i is added into entry (k, x, y). Here k is the weight's output channel, x = act_x − r and y = act_y − s, provided the two input channels are equal and r and s are both below RS.
- R3: A weight lane whose wt_mask bit is 0, or an activation lane whose act_mask bit was 0 when loaded, contributes nothing, whatever its other fields hold.
- R4: A product is dropped when the weight's input channel differs from the activation's, or when the weight's r or s is RS or larger.
- R5: All products of one step that target the same entry are added in full, and wt_ready never falls because of such a collision.
- R6: The activation set is captured on act_load and held until the next act_load. A step in the same cycle as act_load uses the previously held set.
- R7: cmd_clear zeroes every entry at the next edge, and wt_ready is 0 in that cycle. A drain leaves the buffer contents unchanged.
- R8: A drain presents the entries with x running fastest from −(RS−1) to WT−1, then y over the same range ending at HT−1, then k from 0 to K−1. rd_halo is 1 exactly when x or y is negative, rd_last marks the final entry, and rd_valid falls after it is taken.
- R9: While rd_valid is high and rd_ready is low, the presented entry and its fields hold. wt_ready is 0 for the whole drain, and drain_start during a drain is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_clear | input | 1 | Zero the accumulation buffer |
| act_load | input | 1 | Capture the activation vector |
| act_mask | input | I | Valid bit per activation lane |
| act_val | input | I*VW | Signed activation values, lane 0 in the low bits |
| act_x | input | I*XW | Activation column inside the tile |
| act_y | input | I*YW | Activation row inside the tile |
| act_c | input | I*CW | Activation input channel |
| wt_valid | input | 1 | Weight vector offered |
| wt_ready | output | 1 | Weight vector accepted this cycle |
| wt_mask | input | F | Valid bit per weight lane |
| wt_val | input | F*VW | Signed weight values |
| wt_k | input | F*KW | Output channel of each weight |
| wt_c | input | F*CW | Input channel of each weight |
| wt_r | input | F*RW | Horizontal kernel offset |
| wt_s | input | F*RW | Vertical kernel offset |
| drain_start | input | 1 | Begin streaming out the buffer |
| rd_valid | output | 1 | Readout entry present |
| rd_ready | input | 1 | Readout entry taken |
| rd_data | output | AW | Signed partial sum |
| rd_x | output | OW | Signed output column |
| rd_y | output | OW | Signed output row |
| rd_k | output | KW | Output channel |
| rd_halo | output | 1 | Entry lies outside the tile (halo) |
| rd_last | output | 1 | Final entry of the drain |

## Verification
Sixteen sweeps vary the activation and weight densities independently from empty to fully dense. Each drained buffer is compared with a dense direct convolution over the same random operands, which separates correct scattering, channel matching and collision merging from any mis-addressed or lost product. Invalid lanes always carry random non-zero junk, and each sweep adds one valid weight with an out-of-range offset, so masking and range dropping are exercised on every step. Short directed cases isolate a single product, a four-way collision at a halo corner, act_load coinciding with a step, clearing, and a repeated drain. Random rd_ready gaps and a stray drain_start test the readout hold and ordering.

// File: rtl/sparse_cp_pe.sv
module sparse_cp_pe #(
  parameter int F  = 2,
  parameter int I  = 2,
  parameter int VW = 8,
  parameter int AW = 20,
  parameter int C  = 2,
  parameter int K  = 2,
  parameter int WT = 4,
  parameter int HT = 4,
  parameter int RS = 3,
  localparam int XW  = (WT > 1) ? $clog2(WT) : 1,
  localparam int YW  = (HT > 1) ? $clog2(HT) : 1,
  localparam int CW  = (C > 1) ? $clog2(C) : 1,
  localparam int KW  = (K > 1) ? $clog2(K) : 1,
  localparam int RW  = (RS > 1) ? $clog2(RS) : 1,
  localparam int EXW = WT + RS - 1,
  localparam int EXH = HT + RS - 1,
  localparam int OW  = $clog2((EXW > EXH) ? EXW : EXH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_clear,
  input  logic                 act_load,
  input  logic [I-1:0]         act_mask,
  input  logic [I*VW-1:0]      act_val,
  input  logic [I*XW-1:0]      act_x,
  input  logic [I*YW-1:0]      act_y,
  input  logic [I*CW-1:0]      act_c,
  input  logic                 wt_valid,
  output logic                 wt_ready,
  input  logic [F-1:0]         wt_mask,
  input  logic [F*VW-1:0]      wt_val,
  input  logic [F*KW-1:0]      wt_k,
  input  logic [F*CW-1:0]      wt_c,
  input  logic [F*RW-1:0]      wt_r,
  input  logic [F*RW-1:0]      wt_s,
  input  logic                 drain_start,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic signed [AW-1:0] rd_data,
  output logic signed [OW-1:0] rd_x,
  output logic signed [OW-1:0] rd_y,
  output logic [KW-1:0]        rd_k,
  output logic                 rd_halo,
  output logic                 rd_last
);
  localparam int N  = K * EXW * EXH;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int P  = F * I;

  logic [I-1:0]         am_q;
  logic [I*VW-1:0]      av_q;
  logic [I*XW-1:0]      ax_q;
  logic [I*YW-1:0]      ay_q;
  logic [I*CW-1:0]      ac_q;
  logic signed [AW-1:0] acc   [N];
  logic signed [AW-1:0] delta [N];
  logic signed [AW-1:0] prod  [P];
  logic                 hit   [P];
  logic [IW-1:0]        addr  [P];
  logic                 draining;
  logic [IW-1:0]        idx;
  logic                 step;
  int                   ex_o, ey_o;

  assign wt_ready = !draining && !cmd_clear;
  assign step     = wt_valid && wt_ready;

  for (genvar f = 0; f < F; f++) begin : g_wt
    for (genvar i = 0; i < I; i++) begin : g_act
      localparam int PI = f * I + i;
      logic signed [VW-1:0]   wv, av;
      logic signed [2*VW-1:0] m;
      logic [RW-1:0]          r, s;
      assign wv = wt_val[f*VW +: VW];
      assign av = av_q[i*VW +: VW];
      assign m  = wv * av;
      assign r  = wt_r[f*RW +: RW];
      assign s  = wt_s[f*RW +: RW];
      assign prod[PI] = AW'(m);
      assign hit[PI]  = wt_mask[f] && am_q[i] && (wt_c[f*CW +: CW] == ac_q[i*CW +: CW])
                        && (int'(r) < RS) && (int'(s) < RS);
      assign addr[PI] = IW'(int'(wt_k[f*KW +: KW]) * EXW * EXH
                        + (int'(ay_q[i*YW +: YW]) + RS - 1 - int'(s)) * EXW
                        + int'(ax_q[i*XW +: XW]) + RS - 1 - int'(r));
    end
  end

  always_comb begin
    for (int a = 0; a < N; a++) begin
      delta[a] = '0;
      for (int p = 0; p < P; p++)
        if (hit[p] && addr[p] == IW'(a)) delta[a] = delta[a] + prod[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      am_q <= '0;
      av_q <= '0;
      ax_q <= '0;
      ay_q <= '0;
      ac_q <= '0;
      for (int a = 0; a < N; a++) acc[a] <= '0;
      draining <= 1'b0;
      idx      <= '0;
    end else begin
      if (act_load) begin
        am_q <= act_mask;
        av_q <= act_val;
        ax_q <= act_x;
        ay_q <= act_y;
        ac_q <= act_c;
      end
      for (int a = 0; a < N; a++) begin
        if (cmd_clear) acc[a] <= '0;
        else if (step) acc[a] <= acc[a] + delta[a];
      end
      if (draining) begin
        if (rd_ready) begin
          if (idx == IW'(N - 1)) begin
            draining <= 1'b0;
            idx      <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end else if (drain_start) begin
        draining <= 1'b1;
        idx      <= '0;
      end
    end
  end

  always_comb begin
    ex_o = int'(idx) % EXW;
    ey_o = (int'(idx) / EXW) % EXH;
  end

  assign rd_valid = draining;
  assign rd_data  = acc[idx];
  assign rd_x     = OW'(ex_o - (RS - 1));
  assign rd_y     = OW'(ey_o - (RS - 1));
  assign rd_k     = KW'(int'(idx) / (EXW * EXH));
  assign rd_halo  = (ex_o < RS - 1) || (ey_o < RS - 1);
  assign rd_last  = draining && (idx == IW'(N - 1));
endmodule

// File: rtl/sparse_cp_pe_chk.sv
module sparse_cp_pe_chk #(
  parameter int AW = 20,
  parameter int OW = 4,
  parameter int KW = 1,
  parameter int K  = 2,
  parameter int WT = 4,
  parameter int HT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_clear,
  input logic                 wt_ready,
  input logic                 rd_valid,
  input logic                 rd_ready,
  input logic signed [AW-1:0] rd_data,
  input logic signed [OW-1:0] rd_x,
  input logic signed [OW-1:0] rd_y,
  input logic [KW-1:0]        rd_k,
  input logic                 rd_halo,
  input logic                 rd_last
);
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !wt_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cmd_clear) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_x) && $stable(rd_y) && $stable(rd_k)));

  assert_halo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_halo == ((rd_x < 0) || (rd_y < 0))));

  assert_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last) |=> !rd_valid);

  assert_lastpos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last) |-> (rd_k == KW'(K - 1) && rd_x == OW'(WT - 1) && rd_y == OW'(HT - 1)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |-> !wt_ready);
endmodule

bind sparse_cp_pe sparse_cp_pe_chk #(.AW(AW), .OW(OW), .KW(KW), .K(K), .WT(WT), .HT(HT)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_clear(cmd_clear), .wt_ready(wt_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_x(rd_x),
  .rd_y(rd_y), .rd_k(rd_k), .rd_halo(rd_halo), .rd_last(rd_last)
);

// File: tb/test_sparse_cp_pe.sv
module test_sparse_cp_pe;
  localparam int CLK_PERIOD = 10;
  localparam int F = 2, I = 2, VW = 8, AW = 20, C = 2, K = 2, WT = 4, HT = 4, RS = 3;
  localparam int XW = 2, YW = 2, CW = 1, KW = 1, RW = 2, OW = 4;
  localparam int EXW = WT + RS - 1, EXH = HT + RS - 1, N = K * EXW * EXH;

  logic clk = 0, rst_n = 0, cmd_clear = 0, act_load = 0, wt_valid = 0, drain_start = 0, rd_ready = 0;
  logic [I-1:0] act_mask = '0;
  logic [I*VW-1:0] act_val = '0;
  logic [I*XW-1:0] act_x = '0;
  logic [I*YW-1:0] act_y = '0;
  logic [I*CW-1:0] act_c = '0;
  logic [F-1:0] wt_mask = '0;
  logic [F*VW-1:0] wt_val = '0;
  logic [F*KW-1:0] wt_k = '0;
  logic [F*CW-1:0] wt_c = '0;
  logic [F*RW-1:0] wt_r = '0, wt_s = '0;
  logic wt_ready, rd_valid, rd_halo, rd_last;
  logic signed [AW-1:0] rd_data;
  logic signed [OW-1:0] rd_x, rd_y;
  logic [KW-1:0] rd_k;

  int errors = 0, checks = 0, ready_drops = 0;
  int expv [N];
  bit done = 0;

  sparse_cp_pe #(.F(F), .I(I), .VW(VW), .AW(AW), .C(C), .K(K), .WT(WT), .HT(HT), .RS(RS)) i_sparse_cp_pe (
    .clk(clk), .rst_n(rst_n), .cmd_clear(cmd_clear), .act_load(act_load), .act_mask(act_mask),
    .act_val(act_val), .act_x(act_x), .act_y(act_y), .act_c(act_c), .wt_valid(wt_valid),
    .wt_ready(wt_ready), .wt_mask(wt_mask), .wt_val(wt_val), .wt_k(wt_k), .wt_c(wt_c),
    .wt_r(wt_r), .wt_s(wt_s), .drain_start(drain_start), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_x(rd_x), .rd_y(rd_y), .rd_k(rd_k), .rd_halo(rd_halo), .rd_last(rd_last));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eidx(int k, int x, int y);
    return k * EXW * EXH + (y + RS - 1) * EXW + (x + RS - 1);
  endfunction

  function automatic int rnz();
    int v = int'($urandom % 15) - 7;
    return (v == 0) ? 8 : v;
  endfunction

  task automatic set_act(int i, bit m, int v, int x, int y, int c);
    act_mask[i] = m;
    act_val[i*VW +: VW] = VW'(v);
    act_x[i*XW +: XW] = XW'(x);
    act_y[i*YW +: YW] = YW'(y);
    act_c[i*CW +: CW] = CW'(c);
  endtask

  task automatic set_wt(int f, bit m, int v, int k, int c, int r, int s);
    wt_mask[f] = m;
    wt_val[f*VW +: VW] = VW'(v);
    wt_k[f*KW +: KW] = KW'(k);
    wt_c[f*CW +: CW] = CW'(c);
    wt_r[f*RW +: RW] = RW'(r);
    wt_s[f*RW +: RW] = RW'(s);
  endtask

  task automatic junk_act(int i);
    set_act(i, 0, rnz(), $urandom % WT, $urandom % HT, $urandom % C);
  endtask

  task automatic junk_wt(int f);
    set_wt(f, 0, rnz(), $urandom % K, $urandom % C, $urandom % 4, $urandom % 4);
  endtask

  task automatic load_acts();
    act_load = 1;
    @(negedge clk);
    act_load = 0;
  endtask

  task automatic step();
    wt_valid = 1;
    #1;
    if (!wt_ready) ready_drops++;
    @(negedge clk);
    wt_valid = 0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    cmd_clear = 1;
    #1 check(wt_ready == 0, "R7", "wt_ready during clear", int'(wt_ready), 0);
    @(negedge clk);
    cmd_clear = 0;
    for (int e = 0; e < N; e++) expv[e] = 0;
  endtask

  task automatic drain_check(string req);
    @(negedge clk);
    drain_start = 1;
    @(negedge clk);
    drain_start = 0;
    for (int e = 0; e < N; e++) begin
      bit rdy;
      int k = e / (EXW * EXH);
      int y = (e / EXW) % EXH - (RS - 1);
      int x = e % EXW - (RS - 1);
      bit halo = (x < 0) || (y < 0);
      bit last = (e == N - 1);
      do begin
        rdy = ($urandom % 4) != 0;
        rd_ready = rdy;
        drain_start = (e == 10);
        #1;
        check(rd_valid === 1'b1 && wt_ready === 1'b0, "R9", "valid/ready during drain",
              int'(rd_valid), 1);
        check(int'(rd_data) == expv[e], req, $sformatf("data entry %0d", e), int'(rd_data), expv[e]);
        check(int'(rd_x) == x && int'(rd_y) == y && int'(rd_k) == k && rd_halo == halo && rd_last == last,
              "R8", $sformatf("fields entry %0d (x y k halo last packed)", e),
              int'(rd_x) * 10000 + int'(rd_y) * 1000 + int'(rd_k) * 100 + int'(rd_halo) * 10 + int'(rd_last),
              x * 10000 + y * 1000 + k * 100 + int'(halo) * 10 + int'(last));
        @(negedge clk);
        drain_start = 0;
      end while (!rdy);
    end
    rd_ready = 0;
    #1;
    check(rd_valid == 0 && wt_ready == 1, "R8", "drain ended", int'(rd_valid), 0);
  endtask

  task automatic run_dense(int pa, int pw);
    int A [C][WT][HT];
    int W [K][C][RS][RS];
    int lv [C*WT*HT], lx [C*WT*HT], ly [C*WT*HT], lc [C*WT*HT];
    int wv [K*C*RS*RS], wk [K*C*RS*RS], wc [K*C*RS*RS], wr [K*C*RS*RS], ws [K*C*RS*RS];
    int na = 0, nw = 0;
    for (int c = 0; c < C; c++)
      for (int x = 0; x < WT; x++)
        for (int y = 0; y < HT; y++) begin
          A[c][x][y] = (int'($urandom % 100) < pa) ? rnz() : 0;
          if (A[c][x][y] != 0) begin
            lv[na] = A[c][x][y]; lx[na] = x; ly[na] = y; lc[na] = c; na++;
          end
        end
    for (int k = 0; k < K; k++)
      for (int c = 0; c < C; c++)
        for (int r = 0; r < RS; r++)
          for (int s = 0; s < RS; s++) begin
            W[k][c][r][s] = (int'($urandom % 100) < pw) ? rnz() : 0;
            if (W[k][c][r][s] != 0) begin
              wv[nw] = W[k][c][r][s]; wk[nw] = k; wc[nw] = c; wr[nw] = r; ws[nw] = s; nw++;
            end
          end
    do_clear();
    for (int k = 0; k < K; k++)
      for (int xo = -(RS - 1); xo < WT; xo++)
        for (int yo = -(RS - 1); yo < HT; yo++) begin
          int sum = 0;
          for (int c = 0; c < C; c++)
            for (int r = 0; r < RS; r++)
              for (int s = 0; s < RS; s++)
                if (xo + r >= 0 && xo + r < WT && yo + s >= 0 && yo + s < HT)
                  sum += W[k][c][r][s] * A[c][xo + r][yo + s];
          expv[eidx(k, xo, yo)] = sum;
        end
    for (int a0 = 0; a0 < na; a0 += I) begin
      for (int i = 0; i < I; i++)
        if (a0 + i < na) set_act(i, 1, lv[a0 + i], lx[a0 + i], ly[a0 + i], lc[a0 + i]);
        else junk_act(i);
      load_acts();
      for (int w0 = 0; w0 < nw; w0 += F) begin
        for (int f = 0; f < F; f++)
          if (w0 + f < nw) set_wt(f, 1, wv[w0 + f], wk[w0 + f], wc[w0 + f], wr[w0 + f], ws[w0 + f]);
          else junk_wt(f);
        step();
      end
      set_wt(0, 1, rnz(), $urandom % K, $urandom % C, 3, $urandom % RS);
      junk_wt(1);
      step();
    end
    drain_check("R2");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < N; e++) expv[e] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(rd_valid == 0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    check(wt_ready == 1, "R1", "wt_ready after reset", int'(wt_ready), 1);
    drain_check("R1");

    // R2 single product, invalid lanes carry junk (R3)
    do_clear();
    @(negedge clk);
    set_act(0, 1, 3, 1, 2, 0); junk_act(1);
    load_acts();
    set_wt(0, 1, 5, 1, 0, 1, 0); junk_wt(1);
    step();
    set_wt(0, 0, 7, 1, 0, 0, 0); set_wt(1, 0, -6, 0, 0, 1, 1);
    step();
    expv[eidx(1, 0, 2)] = 15;
    drain_check("R3");
    drain_check("R7");

    // R5 four products collide on a halo corner
    do_clear();
    ready_drops = 0;
    @(negedge clk);
    set_act(0, 1, 2, 0, 0, 1); set_act(1, 1, 2, 0, 0, 1);
    load_acts();
    set_wt(0, 1, -3, 0, 1, 2, 2); set_wt(1, 1, -3, 0, 1, 2, 2);
    step();
    check(ready_drops == 0, "R5", "wt_ready drops on collision", ready_drops, 0);
    expv[eidx(0, -2, -2)] = -24;
    drain_check("R5");

    // R4 channel mismatch and out-of-range offsets
    do_clear();
    @(negedge clk);
    set_act(0, 1, 4, 2, 2, 0); set_act(1, 1, 6, 3, 1, 0);
    load_acts();
    set_wt(0, 1, 5, 0, 1, 0, 0); set_wt(1, 1, 5, 1, 0, 3, 0);
    step();
    set_wt(0, 1, 2, 1, 0, 0, 3); set_wt(1, 1, 9, 0, 1, 1, 1);
    step();
    drain_check("R4");

    // R6 act_load in the same cycle as a step
    do_clear();
    @(negedge clk);
    set_act(0, 1, 1, 3, 3, 0); junk_act(1);
    load_acts();
    set_wt(0, 1, 7, 0, 0, 0, 0); junk_wt(1);
    set_act(0, 1, 10, 2, 2, 0);
    act_load = 1;
    step();
    act_load = 0;
    set_act(0, 1, 99, 1, 1, 0);
    step();
    expv[eidx(0, 3, 3)] = 7;
    expv[eidx(0, 2, 2)] = 70;
    drain_check("R6");

    do_clear();
    drain_check("R7");

    ready_drops = 0;
    for (int da = 0; da < 4; da++)
      for (int dw = 0; dw < 4; dw++)
        run_dense(da * 33 + (da == 3 ? 1 : 0), dw * 33 + (dw == 3 ? 1 : 0));
    check(ready_drops == 0, "R5", "wt_ready drops over sweeps", ready_drops, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule